// File: doc/BRIEF.md
# Redundant Trace Mismatch Detector

This block watches the instruction trace of two or three processor copies that are meant to run the same program. It projects each copy's trace word onto a selectable set of signal groups, compares the projections, and raises registered mismatch flags when they differ. With two copies, any difference between the first and second copy counts as an error. With three copies, the block also names the copy that disagrees with both of the others.

Copies may run a fixed number of cycles apart. A delay line of `DEPTH` cycles on copy A lines A up with B and C. The block stays silent until that line, and the optional input register stage, hold real samples. A disable input can mute checking. A sticky status nibble collects every flag that has fired. An inject input forces one miscompare so that software can prove the comparator works.

Top module: `redund_trace_cmp`

## Requirements
- R1: With `MODE_TMR`=0, `cmp_err` rises when the projections of A and B differ. Input C has no effect, and `mis_a`/`mis_b`/`mis_c` stay 0.
- R2: With `MODE_TMR`=1, `cmp_err` rises when any two projections differ. `mis_x` rises when copy x differs from both other copies, so all three rise when all three differ.
- R3: Each trace word has 126 bits, packed from bit 0 upward in this order: valid (0), reg-write (1), reg address (2..6), new reg value (7..38), data access (39), data address (40..71), store value (72..103), byte enables (104..107), read strobe (108), write strobe (109), other trace (110..125). With `SUBSET`=0 every bit is compared.
- R4: With `SUBSET`=1 bit 0 is always compared. Bits 1..38 of a copy count only while that copy's bit 0 is 1 (otherwise they are treated as zero). Bits 39..125 are ignored.
- R5: With `SUBSET`=2 the block compares what R4 compares, and also compares bits 39..109 every cycle. Bits 110..125 are ignored.
- R6: Flags are registered. With `IN_REG`=0 a flag shows up after the clock edge that samples the inputs; with `IN_REG`=1 it shows up one edge later.
- R7: Copy A is delayed by `DEPTH` cycles before it is compared. For the first `DEPTH`+`IN_REG` edges after reset no flag is raised.
- R8: With `DIS_EN`=1 and `chk_off` high at a compare edge, that edge raises no flag and leaves `status` unchanged. With `DIS_EN`=0, `chk_off` has no effect.
- R9: `status` = {err, C, B, A} holds every flag raised since the last clear. `clr` empties it at the next edge, but a flag raised at that same edge is kept. With `STATUS_EN`=0, `status` reads 0.
- R10: With `STATUS_EN`=1 and `INJECT_EN`=1, `inj` high at a compare edge inverts bit 0 of copy B's projection for that edge only. Otherwise `inj` has no effect.
- R11: While `rst` is high, all flags and `status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_a | input | TW (126) | Trace word of copy A (delayed copy) |
| trc_b | input | TW (126) | Trace word of copy B |
| trc_c | input | TW (126) | Trace word of copy C (three-copy mode only) |
| chk_off | input | 1 | Suppresses checking when enabled by `DIS_EN` |
| inj | input | 1 | Forces a miscompare on copy B for one edge |
| clr | input | 1 | Clears sticky status |
| cmp_err | output | 1 | Any compared copies disagree |
| mis_a | output | 1 | Copy A is the odd one out |
| mis_b | output | 1 | Copy B is the odd one out |
| mis_c | output | 1 | Copy C is the odd one out |
| status | output | 4 | Sticky {err, C, B, A} |

## Verification
The bench runs three configurations side by side, and goes after the cases listed here.

- **Delay line and fill window.** Copy A is fed early and the other copies arrive `DEPTH` cycles later. A wrong delay length would flag every cycle of random traffic. A missing fill gate would flag the zeros left in the line after reset.
- **Subset masks.** Differences are planted in the other-trace bits, in the data fields, and in register fields while valid is low. A mask that reaches too far, or one that ignores the valid gate, would raise flags where none are expected.
- **Three-way disagreement.** A case where all three copies differ checks that the copy flags come out right.
- **Control inputs.** Disable, clear and inject are each applied where they matter:
  - disable lands on a real mismatch;
  - clear coincides with a new error, so a clear that wins over a set would lose it;
  - inject is also sent to configurations that must ignore it.

// File: rtl/redund_trace_cmp.sv
`timescale 1ns/1ps
module redund_trace_cmp #(
  parameter bit MODE_TMR  = 1'b1,
  parameter int SUBSET    = 2,
  parameter bit IN_REG    = 1'b1,
  parameter int DEPTH     = 3,
  parameter bit DIS_EN    = 1'b1,
  parameter bit STATUS_EN = 1'b1,
  parameter bit INJECT_EN = 1'b1,
  parameter int REG_W     = 5,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int BE_W      = 4,
  parameter int MISC_W    = 16,
  localparam int TW = 2 + REG_W + DATA_W + 1 + ADDR_W + DATA_W + BE_W + 2 + MISC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] trc_a,
  input  logic [TW-1:0] trc_b,
  input  logic [TW-1:0] trc_c,
  input  logic          chk_off,
  input  logic          inj,
  input  logic          clr,
  output logic          cmp_err,
  output logic          mis_a,
  output logic          mis_b,
  output logic          mis_c,
  output logic [3:0]    status
);
  localparam int DA   = 2 + REG_W + DATA_W;
  localparam int MS   = DA + 1 + ADDR_W + DATA_W + BE_W + 2;
  localparam int FILL = DEPTH + int'(IN_REG);
  localparam logic [TW-1:0] M_V    = TW'(1);
  localparam logic [TW-1:0] M_REG  = ((TW'(1) << DA) - TW'(1)) & ~M_V;
  localparam logic [TW-1:0] M_DATA = ((TW'(1) << MS) - TW'(1)) & ~((TW'(1) << DA) - TW'(1));

  function automatic logic [TW-1:0] proj(input logic [TW-1:0] t);
    logic [TW-1:0] r;
    if (SUBSET == 0) return t;
    r = t & M_V;
    if (t[0]) r = r | (t & M_REG);
    if (SUBSET == 2) r = r | (t & M_DATA);
    return r;
  endfunction

  logic [TW-1:0] a_al, ca, cb, cc;

  generate
    if (DEPTH > 0) begin : g_dly
      logic [TW-1:0] dl [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) dl[i] <= '0;
        end else begin
          dl[0] <= trc_a;
          for (int i = 1; i < DEPTH; i++) dl[i] <= dl[i-1];
        end
      end
      assign a_al = dl[DEPTH-1];
    end else begin : g_nodly
      assign a_al = trc_a;
    end

    if (IN_REG) begin : g_ireg
      always_ff @(posedge clk) begin
        if (rst) begin
          ca <= '0; cb <= '0; cc <= '0;
        end else begin
          ca <= a_al; cb <= trc_b; cc <= trc_c;
        end
      end
    end else begin : g_noireg
      assign ca = a_al;
      assign cb = trc_b;
      assign cc = trc_c;
    end
  endgenerate

  logic ready;
  generate
    if (FILL > 0) begin : g_fill
      localparam int CW = $clog2(FILL + 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (cnt != CW'(FILL)) cnt <= cnt + CW'(1);
      end
      assign ready = (cnt == CW'(FILL));
    end else begin : g_nofill
      assign ready = 1'b1;
    end
  endgenerate

  wire inj_eff = STATUS_EN && INJECT_EN && inj;
  wire off_eff = DIS_EN && chk_off;

  logic [TW-1:0] pa, pb, pc;
  assign pa = proj(ca);
  assign pb = proj(cb) ^ {{(TW-1){1'b0}}, inj_eff};
  assign pc = proj(cc);

  wire ab = (pa != pb);
  wire ac = (pa != pc);
  wire bc = (pb != pc);

  logic [3:0] hit, flg_q, st_q;
  always_comb begin
    if (MODE_TMR) hit = {ab | ac | bc, ac & bc, ab & bc, ab & ac};
    else          hit = {ab, 3'b000};
    if (!ready || off_eff) hit = 4'b0000;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q <= '0;
      st_q  <= '0;
    end else begin
      flg_q <= hit;
      st_q  <= (clr ? 4'b0000 : st_q) | hit;
    end
  end

  assign {cmp_err, mis_c, mis_b, mis_a} = flg_q;
  assign status = STATUS_EN ? st_q : 4'b0000;

  AST_COPY_FLAG_NEEDS_ERR: assert property (@(posedge clk) disable iff (rst) (mis_a | mis_b | mis_c) |-> cmp_err); // R2
  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst) !ready |=> !cmp_err); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst) off_eff |=> (!cmp_err && $stable(st_q))); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst) !clr |=> ((st_q & $past(st_q)) == $past(st_q))); // R9
  AST_STATUS_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (rst) (flg_q & ~st_q) == 4'b0000); // R9
endmodule

// File: tb/redund_trace_cmp_tb.sv
`timescale 1ns/1ps
module redund_trace_cmp_tb;
  localparam int NS = 40;
  localparam int D0 = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic [125:0] ua, ub, uc, a0, b0, c0;
  logic chk_off, inj, clr;
  logic [3:0] f0, f1, f2, s0, s1, s2;

  redund_trace_cmp u_dut (
    .clk(clk), .rst(rst), .trc_a(ua), .trc_b(ub), .trc_c(uc),
    .chk_off(chk_off), .inj(inj), .clr(clr),
    .cmp_err(f0[3]), .mis_c(f0[2]), .mis_b(f0[1]), .mis_a(f0[0]), .status(s0));

  redund_trace_cmp #(.MODE_TMR(1'b0), .SUBSET(1), .IN_REG(1'b0), .DEPTH(0),
                     .DIS_EN(1'b0), .STATUS_EN(1'b1), .INJECT_EN(1'b0)) u_ls (
    .clk(clk), .rst(rst), .trc_a(a0), .trc_b(b0), .trc_c(c0),
    .chk_off(chk_off), .inj(inj), .clr(clr),
    .cmp_err(f1[3]), .mis_c(f1[2]), .mis_b(f1[1]), .mis_a(f1[0]), .status(s1));

  redund_trace_cmp #(.MODE_TMR(1'b1), .SUBSET(0), .IN_REG(1'b0), .DEPTH(0),
                     .DIS_EN(1'b1), .STATUS_EN(1'b0), .INJECT_EN(1'b1)) u_full (
    .clk(clk), .rst(rst), .trc_a(a0), .trc_b(b0), .trc_c(c0),
    .chk_off(chk_off), .inj(inj), .clr(clr),
    .cmp_err(f2[3]), .mis_c(f2[2]), .mis_b(f2[1]), .mis_a(f2[0]), .status(s2));

  typedef struct {
    int          due;
    int          d;
    logic [3:0]  f;
    logic [3:0]  st;
    string       tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, ecnt = 0;
  bit done = 1'b0;

  logic [125:0] ia [NS];
  logic [125:0] ib [NS];
  logic [125:0] ic [NS];
  string tg [NS];
  bit c_inj [NS+6];
  bit c_dis [NS+6];
  bit c_clr [NS+6];
  logic [3:0] sm [3];

  function automatic logic [31:0] h(int n, int k);
    logic [31:0] x;
    x = 32'(n) * 32'h9E3779B1 + 32'(k) * 32'h85EBCA77 + 32'h1234567;
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12);
    return x;
  endfunction

  function automatic logic [125:0] rnd(int n);
    logic [127:0] w;
    w = {h(n, 0), h(n, 1), h(n, 2), h(n, 3)};
    return w[125:0];
  endfunction

  function automatic logic [125:0] getv(int which, int n);
    if (n < 0 || n >= NS) return '0;
    case (which)
      0: return ia[n];
      1: return ib[n];
      default: return ic[n];
    endcase
  endfunction

  // projection per R3/R4/R5
  function automatic logic [125:0] bproj(logic [125:0] t, int sub);
    logic [125:0] r;
    if (sub == 0) return t;
    r = '0;
    r[0] = t[0];
    if (t[0]) r[38:1] = t[38:1];
    if (sub == 2) r[109:39] = t[109:39];
    return r;
  endfunction

  // returns {err, C, B, A} per R1/R2/R10
  function automatic logic [3:0] bcmp(logic [125:0] a, logic [125:0] b, logic [125:0] c,
                                      bit tmr, int sub, bit fi);
    logic [125:0] pa, pb, pc;
    bit xab, xac, xbc;
    pa = bproj(a, sub);
    pb = bproj(b, sub);
    pc = bproj(c, sub);
    pb[0] = pb[0] ^ fi;
    xab = (pa != pb); xac = (pa != pc); xbc = (pb != pc);
    if (tmr) return {xab | xac | xbc, xac & xbc, xab & xbc, xab & xac};
    return {xab, 3'b000};
  endfunction

  task automatic push(int due, int d, logic [3:0] f, bit cl, string t);
    exp_t e;
    sm[d] = (cl ? 4'b0000 : sm[d]) | f;
    e.due = due; e.d = d; e.f = f; e.tag = t;
    e.st = (d == 2) ? 4'b0000 : sm[d];
    q.push_back(e);
  endtask

  task automatic chk(string t, logic [7:0] act, logic [7:0] expv, string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", t, what, act, expv);
    end
  endtask

  // monitor: pops expected results due at this edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst) begin
        while (q.size() > 0 && q[0].due == ecnt) begin
          exp_t e;
          logic [7:0] act;
          e = q.pop_front();
          case (e.d)
            0: act = {f0, s0};
            1: act = {f1, s1};
            default: act = {f2, s2};
          endcase
          chk(e.tag, act, {e.f, e.st}, $sformatf("dut%0d edge%0d {flags,status}", e.d, ecnt));
        end
        ecnt++;
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // driver
  initial begin
    for (int n = 0; n < NS; n++) begin
      ia[n] = rnd(n); ib[n] = ia[n]; ic[n] = ia[n]; tg[n] = "R3 R6";
    end
    for (int n = 0; n < NS + 6; n++) begin
      c_inj[n] = 0; c_dis[n] = 0; c_clr[n] = 0;
    end
    ia[5][0] = 1'b1;  ib[5] = ia[5];  ic[5] = ia[5];  ib[5][2] ^= 1'b1;   tg[5] = "R2 R4";
    ic[8][113] ^= 1'b1;                                                    tg[8] = "R1 R5";
    ia[11][47] ^= 1'b1;                                                    tg[11] = "R5";
    ia[14][0] = 1'b0; ib[14] = ia[14]; ic[14] = ia[14]; ib[14][8] ^= 1'b1; tg[14] = "R4 R3";
    ia[17][0] = 1'b1; ib[17] = ia[17]; ic[17] = ia[17];
    ib[17][7] ^= 1'b1; ic[17][9] ^= 1'b1;                                   tg[17] = "R2 R1";
    ia[20][0] = 1'b1; ib[20] = ia[20]; ic[20] = ia[20]; ic[20][12] ^= 1'b1; tg[20] = "R1 R2";
    ia[23][0] = 1'b1; ib[23] = ia[23]; ic[23] = ia[23]; ia[23][0] = 1'b0;  tg[23] = "R4";
    ia[24][0] = 1'b1; ib[24] = ia[24]; ic[24] = ia[24]; ia[24][10] ^= 1'b1;
    c_dis[24] = 1;                                                         tg[24] = "R8";
    c_clr[26] = 1;                                                         tg[26] = "R9";
    ia[27][0] = 1'b1; ib[27] = ia[27]; ic[27] = ia[27]; ib[27][3] ^= 1'b1;
    c_clr[27] = 1;                                                         tg[27] = "R9";
    c_inj[29] = 1;                                                         tg[29] = "R10";
    c_clr[33] = 1;                                                         tg[33] = "R9";
    for (int d = 0; d < 3; d++) sm[d] = 4'b0000;

    rst = 1'b1; chk_off = 1'b0; inj = 1'b0; clr = 1'b0;
    ua = rnd(100); ub = rnd(101); uc = rnd(102);
    a0 = rnd(103); b0 = rnd(104); c0 = rnd(105);
    repeat (3) @(negedge clk);
    chk("R11", {f0, s0}, 8'h00, "dut0 in reset");
    chk("R11", {f1, s1}, 8'h00, "dut1 in reset");
    chk("R11", {f2, s2}, 8'h00, "dut2 in reset");

    for (int s = 0; s < NS + D0 + 3; s++) begin
      int i;
      string t;
      logic [3:0] f;
      @(negedge clk);
      rst = 1'b0;
      ua = getv(0, s); ub = getv(1, s - D0); uc = getv(2, s - D0);
      a0 = getv(0, s); b0 = getv(1, s);      c0 = getv(2, s);
      chk_off = c_dis[s]; inj = c_inj[s]; clr = c_clr[s];

      // dut0: item s-1-DEPTH compared at this edge; silent while filling (R7)
      i = s - 1 - D0;
      if (c_inj[s] || c_dis[s] || c_clr[s]) t = tg[s];
      else if (i >= 0 && i < NS) t = tg[i];
      else t = "R7";
      if (i < 0 || c_dis[s]) f = 4'b0000;
      else f = bcmp(getv(0, i), getv(1, i), getv(2, i), 1'b1, 2, c_inj[s]);
      push(s, 0, f, c_clr[s], t);

      // dut1 and dut2: same-edge compare
      t = (s < NS) ? tg[s] : "R6";
      f = bcmp(getv(0, s), getv(1, s), getv(2, s), 1'b0, 1, 1'b0);
      push(s, 1, f, c_clr[s], t);
      f = c_dis[s] ? 4'b0000 : bcmp(getv(0, s), getv(1, s), getv(2, s), 1'b1, 0, 1'b0);
      push(s, 2, f, c_clr[s], t);
    end
    @(negedge clk);
    chk_off = 1'b0; inj = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R6 pending results actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule